// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight level-sensitive interrupt requests, registers them on the system clock, and filters them through a per-level mask. Among the pending unmasked levels it picks a winner using one of three priority schemes, which software can switch at any time. The schemes are fixed order, rotation after service, and a software-chosen lowest level. It drives one interrupt line to the host only when that winner outranks every level already in service. This lets a higher-priority source interrupt a lower one, while equal or lower sources wait.

The host talks to it over a byte-wide register bus with two addresses. The host acknowledges with a one-cycle pulse. This moves the winner into the in-service set and presents its level number. It ends service with a command, and can also poll for the winner instead of using the acknowledge line. Request, in-service and mask contents can all be read back.

Top module: `pic_ctrl`

## Requirements
- R1: Each request input is sampled on every rising clock edge into the request register. A request that drops before acknowledge is not serviced: the acknowledge then leaves `vec_vld_o` low.
- R2: A write to address 1 loads the mask register from `wdata_i[7:0]`. A read of address 1 returns it. A set bit removes that level from interrupt and acknowledge decisions.
- R3: In fixed mode (priority command `wdata_i[3]=0`, `wdata_i[1:0]=00` or `11`), level 0 ranks highest and level 7 lowest.
- R4: In rotating mode (`wdata_i[1:0]=01`), level 7 is lowest after reset. Each end-of-service makes the level it clears the lowest, and the following levels rank upward from it with wrap-around.
- R5: In assigned mode (`wdata_i[1:0]=10`), `wdata_i[6:4]` names the lowest level L. The order from highest to lowest is L+1, L+2, ..., wrapping modulo 8, ending at L.
- R6: `int_o` is high exactly when some unmasked request is pending and the winner ranks strictly above the highest-ranked in-service level, or nothing is in service.
- R7: An `ack_i` pulse sets the winner's in-service bit. One cycle later it shows the winner's number on `vec_o` with `vec_vld_o` high. With nothing pending, `vec_vld_o` goes low and the in-service set is unchanged.
- R8: A service command with `wdata_i[0]=1` (end-of-service) clears only the highest-ranked in-service bit.
- R9: A service command (`wdata_i[3]=1`) with `wdata_i[2:1]=00` makes address-0 reads return the request register. With `01` they return the in-service register. `11` leaves the choice unchanged.
- R10: A service command with `wdata_i[2:1]=10` arms a poll. The next address-0 read returns bit 7 = valid and bits 2:0 = winning level (zero when nothing is pending), and acts as an acknowledge. Later reads return the selected register again.
- R11: Changing the priority scheme keeps the request, mask and in-service contents. The new ranking takes effect on the next decision.
- R12: After reset the mask, request and in-service registers are zero, the scheme is fixed, reads select the request register, and `int_o` and `vec_vld_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Level-sensitive interrupt requests, bit n = level n |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register address (0 = command/status, 1 = mask) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle `rd_i` is high |
| ack_i | input | 1 | Host acknowledge pulse |
| int_o | output | 1 | Interrupt request to host |
| vec_o | output | 3 | Level number of the last acknowledged winner |
| vec_vld_o | output | 1 | High when the last acknowledge found a pending level |

## Verification
The hardest condition to reach from the ports is a nested decision: a specific level already in service while a fresh pattern of requests arrives. Each part of that condition must also be ranked under a non-default priority origin. The stimulus builds it in three steps. It raises a single request and acknowledges it to place exactly one level in service. It then applies every one of the 256 request patterns and compares `int_o` with a rank computed in the bench. This is repeated for every in-service level under both fixed order and an assigned lowest level. Rotation is reached by chaining acknowledge and end-of-service, with the bench tracking the moving lowest level itself.

// File: rtl/pic_pkg.sv
// Package: shared types and command field positions for the interrupt controller.
// Assumes an 8-bit register bus; field positions below are part of the host contract.
package pic_pkg;

    typedef enum logic [1:0] {
        SCH_FIXED    = 2'b00,
        SCH_ROTATE   = 2'b01,
        SCH_ASSIGNED = 2'b10
    } scheme_e;

    typedef enum logic [0:0] {
        RSEL_REQ = 1'b0,
        RSEL_ISR = 1'b1
    } rsel_e;

    localparam int CMD_KIND_BIT = 3;   // 0 = priority command, 1 = service command
    localparam int EOS_BIT      = 0;   // end-of-service flag in a service command
    localparam int SEL_LSB      = 1;   // two-bit read-select field in a service command
    localparam int LOW_LSB      = 4;   // lowest-level field in a priority command

endpackage

// File: rtl/pic_rank.sv
// Module: pic_rank
// Finds, in a set of levels, the one ranked highest when level low_i is the
// lowest and the others follow upward from low_i+1 with wrap-around.
// Also reports that level's rank (0 = highest). Purely combinational.
module pic_rank #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [LW-1:0] low_i,
    output logic          found_o,
    output logic [LW-1:0] idx_o,
    output logic [LW-1:0] rank_o
);

    logic [LW-1:0] pos_w;

    // Scan levels from highest rank to lowest and keep the first one present.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        rank_o  = '0;
        pos_w   = '0;
        for (int k = 0; k < N; k++) begin
            pos_w = LW'((int'(low_i) + 1 + k) % N);
            if (!found_o && vec_i[pos_w]) begin
                found_o = 1'b1;
                idx_o   = pos_w;
                rank_o  = LW'(k);
            end
        end
    end

    // R3/R5: a reported winner must be a member of the input set.
    always_comb begin
        if (found_o) begin
            a_r3_winner_in_set: assert (vec_i[idx_o])
                else $error("winner not in set");
        end
    end

endmodule

// File: rtl/pic_prio_ptr.sv
// Module: pic_prio_ptr
// Holds the active priority scheme, the software-assigned lowest level and the
// rotating lowest level; presents the lowest level that the resolvers use.
// Assumes rot_adv_i is only raised by the top when the scheme is rotating.
module pic_prio_ptr
    import pic_pkg::*;
#(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prio_we_i,
    input  scheme_e       scheme_wr_i,
    input  logic [LW-1:0] low_wr_i,
    input  logic          rot_adv_i,
    input  logic [LW-1:0] rot_lvl_i,
    output scheme_e       scheme_o,
    output logic [LW-1:0] low_o
);

    localparam logic [LW-1:0] LOW_FIXED = LW'(N - 1);

    scheme_e       scheme_q;
    logic [LW-1:0] assigned_q;
    logic [LW-1:0] rotate_q;

    // Scheme and assigned-lowest registers, loaded by a priority command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scheme_q   <= SCH_FIXED;
            assigned_q <= LOW_FIXED;
        end else if (prio_we_i) begin
            scheme_q <= scheme_wr_i;
            if (scheme_wr_i == SCH_ASSIGNED) begin
                assigned_q <= low_wr_i;
            end
        end
    end

    // Rotating lowest level, moved by each end-of-service in rotating mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rotate_q <= LOW_FIXED;
        end else if (rot_adv_i) begin
            rotate_q <= rot_lvl_i;
        end
    end

    // Select the lowest level for the active scheme.
    always_comb begin
        unique case (scheme_q)
            SCH_ROTATE:   low_o = rotate_q;
            SCH_ASSIGNED: low_o = assigned_q;
            default:      low_o = LOW_FIXED;
        endcase
    end

    assign scheme_o = scheme_q;

    // R4: after an end-of-service in rotating mode the cleared level is lowest.
    a_r4_rot_follows_eos: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_adv_i && scheme_q == SCH_ROTATE && !prio_we_i) |=> (low_o == $past(rot_lvl_i)));

    // R3: fixed mode always ranks the top-numbered level lowest.
    a_r3_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
        (scheme_q == SCH_FIXED) |-> (low_o == LOW_FIXED));

endmodule

// File: rtl/pic_host_if.sv
// Module: pic_host_if
// Decodes the two-address register bus into strobes, keeps the read-select
// and poll-arm state, and builds the read data. Assumes rd_i and wr_i are
// single-cycle strobes; read data is combinational in the strobe cycle.
module pic_host_if
    import pic_pkg::*;
#(
    parameter int N  = 8,
    parameter int LW = $clog2(N),
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic          addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  irr_i,
    input  logic [N-1:0]  isr_i,
    input  logic [N-1:0]  mask_i,
    input  logic          poll_found_i,
    input  logic [LW-1:0] poll_lvl_i,
    output logic [DW-1:0] rdata_o,
    output logic          mask_we_o,
    output logic          prio_we_o,
    output scheme_e       scheme_wr_o,
    output logic [LW-1:0] low_wr_o,
    output logic          eos_o,
    output logic          poll_ack_o
);

    rsel_e       sel_q;
    logic        arm_q;
    logic        svc_we;
    logic [1:0]  sel_fld;
    logic        arm_wr;
    logic        unused_msb;

    assign svc_we     = wr_i && !addr_i && wdata_i[CMD_KIND_BIT];
    assign prio_we_o  = wr_i && !addr_i && !wdata_i[CMD_KIND_BIT];
    assign mask_we_o  = wr_i && addr_i;
    assign sel_fld    = wdata_i[SEL_LSB +: 2];
    assign arm_wr     = svc_we && (sel_fld == 2'b10);
    assign eos_o      = svc_we && wdata_i[EOS_BIT];
    assign poll_ack_o = rd_i && !addr_i && arm_q;
    assign low_wr_o   = wdata_i[LOW_LSB +: LW];
    assign unused_msb = wdata_i[DW-1];

    // Map the two-bit scheme field; the spare code behaves as fixed order.
    always_comb begin
        unique case (wdata_i[1:0])
            2'b01:   scheme_wr_o = SCH_ROTATE;
            2'b10:   scheme_wr_o = SCH_ASSIGNED;
            default: scheme_wr_o = SCH_FIXED;
        endcase
    end

    // Read-select register, changed only by a service command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= RSEL_REQ;
        end else if (svc_we) begin
            if (sel_fld == 2'b00) sel_q <= RSEL_REQ;
            else if (sel_fld == 2'b01) sel_q <= RSEL_ISR;
        end
    end

    // Poll arm: set by a service command, cleared by the poll read it serves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (arm_wr) begin
            arm_q <= 1'b1;
        end else if (poll_ack_o) begin
            arm_q <= 1'b0;
        end
    end

    // Read data multiplexer.
    always_comb begin
        rdata_o = '0;
        if (addr_i) begin
            rdata_o = DW'(mask_i);
        end else if (arm_q) begin
            rdata_o[DW-1]   = poll_found_i;
            rdata_o[LW-1:0] = poll_found_i ? poll_lvl_i : '0;
        end else if (sel_q == RSEL_ISR) begin
            rdata_o = DW'(isr_i);
        end else begin
            rdata_o = DW'(irr_i);
        end
    end

    // R10: a poll is served once; the next read sees the selected register.
    a_r10_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_ack_o && !arm_wr) |=> !poll_ack_o);

    // R2: mask writes and priority commands never coincide.
    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mask_we_o, prio_we_o, svc_we}) <= 1);

endmodule

// File: rtl/pic_ctrl.sv
// Module: pic_ctrl (top)
// Eight-level priority interrupt controller: request, mask and in-service
// registers, two rank resolvers sharing one priority origin, nested-service
// gating of the interrupt line, acknowledge and end-of-service handling.
// Assumes ack_i is a one-cycle pulse and requests are synchronous to clk.
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic          addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic          ack_i,
    output logic          int_o,
    output logic [LW-1:0] vec_o,
    output logic          vec_vld_o
);

    logic [N-1:0]  irr_q;
    logic [N-1:0]  isr_q;
    logic [N-1:0]  isr_d;
    logic [N-1:0]  mask_q;
    logic [N-1:0]  pend;
    logic          mask_we;
    logic          prio_we;
    scheme_e       scheme_wr;
    scheme_e       scheme;
    logic [LW-1:0] low_wr;
    logic [LW-1:0] low;
    logic          eos;
    logic          poll_ack;
    logic          take;
    logic          p_found;
    logic [LW-1:0] p_idx;
    logic [LW-1:0] p_rank;
    logic          s_found;
    logic [LW-1:0] s_idx;
    logic [LW-1:0] s_rank;
    logic          rot_adv;
    logic [LW-1:0] vec_q;
    logic          vld_q;

    pic_host_if #(.N(N), .LW(LW), .DW(DW)) u_host (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_i),
        .rd_i         (rd_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .irr_i        (irr_q),
        .isr_i        (isr_q),
        .mask_i       (mask_q),
        .poll_found_i (p_found),
        .poll_lvl_i   (p_idx),
        .rdata_o      (rdata_o),
        .mask_we_o    (mask_we),
        .prio_we_o    (prio_we),
        .scheme_wr_o  (scheme_wr),
        .low_wr_o     (low_wr),
        .eos_o        (eos),
        .poll_ack_o   (poll_ack)
    );

    pic_prio_ptr #(.N(N), .LW(LW)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .prio_we_i   (prio_we),
        .scheme_wr_i (scheme_wr),
        .low_wr_i    (low_wr),
        .rot_adv_i   (rot_adv),
        .rot_lvl_i   (s_idx),
        .scheme_o    (scheme),
        .low_o       (low)
    );

    assign pend = irr_q & ~mask_q;

    pic_rank #(.N(N), .LW(LW)) u_pend_rank (
        .vec_i   (pend),
        .low_i   (low),
        .found_o (p_found),
        .idx_o   (p_idx),
        .rank_o  (p_rank)
    );

    pic_rank #(.N(N), .LW(LW)) u_svc_rank (
        .vec_i   (isr_q),
        .low_i   (low),
        .found_o (s_found),
        .idx_o   (s_idx),
        .rank_o  (s_rank)
    );

    assign take    = ack_i || poll_ack;
    assign rot_adv = eos && s_found && (scheme == SCH_ROTATE);

    // Nested gating: interrupt only when the winner outranks all in service.
    assign int_o = p_found && (!s_found || (p_rank < s_rank));

    // Request register follows the inputs one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= req_i;
    end

    // Mask register, loaded from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata_i[N-1:0];
    end

    // Next in-service set: clear the top in-service level, add the winner.
    always_comb begin
        isr_d = isr_q;
        if (eos && s_found) isr_d[s_idx] = 1'b0;
        if (take && p_found) isr_d[p_idx] = 1'b1;
    end

    // In-service register.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_d;
    end

    // Level number presented to the host on each acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            vld_q <= 1'b0;
        end else if (ack_i) begin
            vec_q <= p_found ? p_idx : '0;
            vld_q <= p_found;
        end
    end

    assign vec_o     = vec_q;
    assign vec_vld_o = vld_q;

    // R6: the interrupt line needs a pending unmasked request.
    a_r6_int_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> (|(irr_q & ~mask_q)));

    // R7: in-service bits are only set by an acknowledge or a poll read.
    a_r7_isr_set_by_take: assert property (@(posedge clk) disable iff (!rst_n)
        (|(isr_q & ~$past(isr_q))) |-> $past(take));

    // R8: end-of-service without a concurrent acknowledge drops exactly one bit.
    a_r8_eos_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && (|isr_q) && !take) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

    // R2: a mask write is visible on the next cycle.
    a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(wdata_i[N-1:0])));

    // R7: an acknowledged level shows up on vec_o in the following cycle.
    a_r7_vec_in_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && p_found && !eos) |=> (vec_vld_o && isr_q[vec_o]));

endmodule

// File: tb/tb_pic_ctrl.sv
// Bench for pic_ctrl: sweeps request patterns, masks, in-service levels and
// priority origins; expected winners and ranks are computed arithmetically.
module tb_pic_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack = 1'b0;
    logic       intr;
    logic [2:0] vec;
    logic       vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    pic_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .rd_i(rd),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack),
        .int_o(intr), .vec_o(vec), .vec_vld_o(vld)
    );

    // Command byte encodings from the requirements.
    localparam logic [7:0] C_FIXED   = 8'h00;
    localparam logic [7:0] C_ROTATE  = 8'h01;
    localparam logic [7:0] C_SEL_REQ = 8'h08;
    localparam logic [7:0] C_SEL_ISR = 8'h0A;
    localparam logic [7:0] C_POLL    = 8'h0C;
    localparam logic [7:0] C_EOS     = 8'h0F;

    function automatic logic [7:0] c_assigned(int l);
        return 8'((l << 4) | 2);
    endfunction

    function automatic int rank_of(int lvl, int low);
        return (lvl - low - 1 + 16) % 8;
    endfunction

    function automatic int winner(int v, int low);
        for (int k = 0; k < 8; k++) begin
            if (v[(low + 1 + k) % 8]) return (low + 1 + k) % 8;
        end
        return -1;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic a, logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(logic a, output logic [7:0] d);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic set_req(logic [7:0] v);
        req = v;
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int low;
        int w;
        int s;
        int exp_int;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state.
        check("R12 int", int'(intr), 0);
        check("R12 vld", int'(vld), 0);
        bus_rd(1'b1, d); check("R12 mask", int'(d), 0);
        bus_rd(1'b0, d); check("R12 req read", int'(d), 0);

        // R1/R9: requests are registered and readable.
        set_req(8'hA5);
        bus_rd(1'b0, d); check("R1 req read", int'(d), 'hA5);
        set_req(8'h08); set_req(8'h00);
        pulse_ack();
        check("R1 dropped request", int'(vld), 0);

        // R3/R6/R7/R8: fixed order, every request pattern.
        for (int p = 0; p < 256; p++) begin
            set_req(8'(p));
            w = winner(p, 7);
            check("R3 int fixed", int'(intr), (w >= 0) ? 1 : 0);
            pulse_ack();
            check("R7 vld fixed", int'(vld), (w >= 0) ? 1 : 0);
            if (w >= 0) begin
                check("R3 vec fixed", int'(vec), w);
                check("R6 no self nest", int'(intr), 0);
            end
            bus_wr(1'b0, C_EOS);
        end
        set_req(8'h00);

        // R5: assigned lowest level, every origin and pattern.
        for (int l = 0; l < 8; l++) begin
            bus_wr(1'b0, c_assigned(l));
            for (int p = 1; p < 256; p++) begin
                set_req(8'(p));
                pulse_ack();
                check("R5 vec assigned", int'(vec), winner(p, l));
                bus_wr(1'b0, C_EOS);
            end
        end

        // R6: nested gating against one in-service level, fixed and assigned (low 2).
        for (int m = 0; m < 2; m++) begin
            low = (m == 0) ? 7 : 2;
            bus_wr(1'b0, (m == 0) ? C_FIXED : c_assigned(2));
            for (s = 0; s < 8; s++) begin
                for (int p = 0; p < 256; p++) begin
                    set_req(8'(1 << s));
                    pulse_ack();
                    set_req(8'(p));
                    w = winner(p, low);
                    exp_int = (w >= 0 && rank_of(w, low) < rank_of(s, low)) ? 1 : 0;
                    check("R6 nested int", int'(intr), exp_int);
                    bus_wr(1'b0, C_EOS);
                end
            end
        end
        bus_wr(1'b0, C_FIXED);
        set_req(8'h00);

        // R2: every mask against all requests.
        req = 8'hFF;
        for (int m = 0; m < 256; m++) begin
            bus_wr(1'b1, 8'(m));
            if (m % 37 == 0) begin bus_rd(1'b1, d); check("R2 mask read", int'(d), m); end
            w = winner((~m) & 'hFF, 7);
            check("R2 masked int", int'(intr), (w >= 0) ? 1 : 0);
            pulse_ack();
            check("R2 masked vld", int'(vld), (w >= 0) ? 1 : 0);
            if (w >= 0) check("R2 masked vec", int'(vec), w);
            bus_wr(1'b0, C_EOS);
        end
        bus_wr(1'b1, 8'h00);
        set_req(8'h00);

        // R4: rotation follows each end-of-service.
        bus_wr(1'b0, C_ROTATE);
        low = 7;
        for (int i = 0; i < 24; i++) begin
            int pat;
            pat = ((i * 37 + 11) & 'hFF) | (1 << (i % 8));
            set_req(8'(pat));
            w = winner(pat, low);
            pulse_ack();
            check("R4 rotate vec", int'(vec), w);
            bus_wr(1'b0, C_EOS);
            low = w;
        end
        set_req(8'h00);

        // R11: switch scheme with state present.
        bus_wr(1'b0, c_assigned(0));
        set_req(8'h81);
        pulse_ack();
        check("R11 assigned winner", int'(vec), 7);
        bus_wr(1'b0, C_FIXED);
        check("R11 int after switch", int'(intr), 1);
        bus_wr(1'b0, C_SEL_ISR);
        bus_rd(1'b0, d); check("R11 isr kept", int'(d), 'h80);
        pulse_ack();
        check("R11 fixed winner", int'(vec), 0);
        bus_wr(1'b0, C_EOS); bus_wr(1'b0, C_EOS);
        bus_rd(1'b0, d); check("R8 all cleared", int'(d), 0);

        // R8: end-of-service removes only the top in-service level.
        set_req(8'h80); pulse_ack();
        set_req(8'h08); pulse_ack();
        set_req(8'h01); pulse_ack();
        bus_rd(1'b0, d); check("R8 three in service", int'(d), 'h89);
        bus_wr(1'b0, C_EOS);
        bus_rd(1'b0, d); check("R8 first eos", int'(d), 'h88);
        bus_wr(1'b0, C_EOS);
        bus_rd(1'b0, d); check("R8 second eos", int'(d), 'h80);
        bus_wr(1'b0, C_EOS);
        bus_rd(1'b0, d); check("R8 third eos", int'(d), 0);

        // R10/R9: poll read returns winner once and acts as acknowledge.
        bus_wr(1'b0, C_SEL_REQ);
        set_req(8'h30);
        bus_wr(1'b0, C_POLL);
        bus_rd(1'b0, d); check("R10 poll byte", int'(d), 'h84);
        bus_rd(1'b0, d); check("R10 one shot", int'(d), 'h30);
        bus_wr(1'b0, C_SEL_ISR);
        bus_rd(1'b0, d); check("R10 poll acked", int'(d), 'h10);
        bus_wr(1'b0, C_EOS);
        set_req(8'h00);
        bus_wr(1'b0, C_POLL);
        bus_rd(1'b0, d); check("R10 empty poll", int'(d), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule